// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-programmed management master for one external PHY. Software writes a command word that selects a read or a write and names the PHY and the register within it. The block then sends one clause-22 management frame on the MDC clock and the MDIO data line, MSB first. A status flag stays high for the whole transfer. When a read finishes, the 16 bits the PHY returned are held in the data register.

A self-control register sets the MDC rate as a programmable divisor of the system clock. It also has an option that drops the 32-bit run of ones at the start of each frame, and a soft-reset bit that clears itself. Access is through a plain single-cycle write strobe, a 2-bit word address and a registered read-data bus. MDIO uses separate output, output-enable and input pins, so the pad tri-state is built outside the block.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, reg_rdata returns 0 for the command, data and status words. The self-control word reads 39 in bits 14:9 (divisor 40), with bits 8 and 0 clear. mdc and mdio_oe are both 0.
- R2: A command write starts a transfer only when bit 15 (read) or bit 14 (write) is set. If both are set, the transfer is a read. If neither is set, nothing starts. The PHY address is taken from bits 9:5 and the register number from bits 4:0.
- R3: A full frame is 64 bit periods: 32 ones, start 01, opcode 10 (read) or 01 (write), the 5-bit PHY address, the 5-bit register number, turnaround 10 on a write, then 16 data bits. On a write, the data bits come from the data register, loaded before the command.
- R4: When self-control bit 8 is 1, the 32 ones are left out and the frame is 32 bit periods long, starting with the start bits.
- R5: On a read, mdio_oe is 0 for the two turnaround periods and the 16 data periods. mdio_i is sampled at each rising MDC edge of the data periods. When the transfer ends, the data register holds the sampled word, first bit as MSB.
- R6: The divisor is N = field(bits 14:9) + 1, and a field value of 0 acts as N = 2. Each bit period lasts N clocks: MDC is low for floor(N/2) clocks, then high for the rest. The transfer keeps status busy for exactly bits × N clocks.
- R7: Status bit 0 reads 1 from the clock edge that accepts a command until the last bit period ends. Whenever the block is not busy, mdc and mdio_oe are 0.
- R8: While a transfer runs, writes to the command word, the data word and the self-control divisor or bit 8 are ignored.
- R9: Writing self-control with bit 0 set stops any transfer at once. Bit 0 then reads 1 for RST_CYCLES clocks (default 8) and clears by itself. The divisor field returns to 39, bit 8 and the data word return to 0, and all writes are ignored while bit 0 reads 1.
- R10: Word addresses are 0 command, 1 data, 2 status, 3 self-control. The word at reg_addr appears on reg_rdata one clock later. The command word reads back bits 15:14 and 9:0 of the last command accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions check on every cycle that the line is quiet while the block is idle. They also check that mdio_oe stays low over the read turnaround and data, that a transfer starts only from a command write carrying an operation bit, that the command, data and divisor registers hold still during a transfer, and that no transfer runs during soft reset. The bench scenarios show what no single cycle can: the exact bit sequence of each frame against a PHY model, the MDC duty cycle and transfer length for several divisors, the read word that comes back, and the length of soft reset with the defaults it restores.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;
  localparam int PRE_BITS = 32;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_SCTL = 2'd3;

  localparam int CMD_RD_BIT   = 15;
  localparam int CMD_WR_BIT   = 14;
  localparam int SCTL_DIV_LSB = 9;
  localparam int SCTL_SUP_BIT = 8;
  localparam int SCTL_RST_BIT = 0;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;
endpackage

// File: rtl/mdio_div_phase.sv
module mdio_div_phase #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             mdc,
  output logic             bit_end,
  output logic             rise_now
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] n_eff;
  logic [CW-1:0] half;
  logic [CW-1:0] ph;

  // divisor below 2 is clamped so that both MDC phases exist
  always_comb begin
    n_eff    = (div_m1 == '0) ? CW'(2) : (CW'(div_m1) + CW'(1));
    half     = n_eff >> 1;
    bit_end  = run && (ph == (n_eff - CW'(1)));
    rise_now = run && ((ph + CW'(1)) == half);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph  <= '0;
      mdc <= 1'b0;
    end else if (bit_end) begin
      ph  <= '0;
      mdc <= 1'b0;
    end else begin
      ph <= ph + CW'(1);
      if (rise_now) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_ctl_pkg::*;
#(
  parameter int ADR_W  = 5,
  parameter int DATA_W = 16,
  parameter int PRE_W  = PRE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              op_rd,
  input  logic              skip_pre,
  input  logic [ADR_W-1:0]  phy,
  input  logic [ADR_W-1:0]  regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bit_end,
  input  logic              rise_now,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_fin,
  output logic [DATA_W-1:0] rd_word
);
  localparam int BODY_W = 6 + 2 * ADR_W + DATA_W;
  localparam int FULL_W = PRE_W + BODY_W;
  localparam int TAIL_W = DATA_W + 2;
  localparam int CNT_W  = $clog2(FULL_W + 1);

  logic [FULL_W-1:0] sr;
  logic [CNT_W-1:0]  rem;
  logic              rd_q;
  logic [DATA_W-1:0] shin;
  logic [BODY_W-1:0] body;
  mdio_opc_e         opc;

  always_comb begin
    opc  = op_rd ? OPC_READ : OPC_WRITE;
    body = {2'b01, opc, phy, regn, (op_rd ? 2'b00 : 2'b10),
            (op_rd ? {DATA_W{1'b0}} : wdata)};
  end

  assign mdio_o  = sr[FULL_W-1];
  assign rd_fin  = busy && rd_q && bit_end && (rem == CNT_W'(1));
  assign rd_word = shin;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy    <= 1'b0;
      sr      <= '1;
      rem     <= '0;
      mdio_oe <= 1'b0;
      rd_q    <= 1'b0;
      shin    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        mdio_oe <= 1'b1;
        rd_q    <= op_rd;
        shin    <= '0;
        if (skip_pre) begin
          sr  <= {body, {PRE_W{1'b1}}};
          rem <= CNT_W'(BODY_W);
        end else begin
          sr  <= {{PRE_W{1'b1}}, body};
          rem <= CNT_W'(FULL_W);
        end
      end
    end else begin
      if (rise_now && rd_q && (rem <= CNT_W'(DATA_W)))
        shin <= {shin[DATA_W-2:0], mdio_i};
      if (bit_end) begin
        if (rem == CNT_W'(1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          sr      <= '1;
        end else begin
          sr      <= sr << 1;
          rem     <= rem - CNT_W'(1);
          mdio_oe <= !(rd_q && ((rem - CNT_W'(1)) <= CNT_W'(TAIL_W)));
        end
      end
    end
  end

  AST_READ_TAIL_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (rem <= CNT_W'(TAIL_W))) |-> !mdio_oe); // R5
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_ctl_pkg::*;
#(
  parameter int DIV_W      = 6,
  parameter int DEF_DIV    = 40,
  parameter int RST_CYCLES = 8,
  parameter int ADR_W      = 5,
  parameter int DATA_W     = 16,
  parameter int RDW        = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  output logic           mdc,
  output logic           mdio_o,
  output logic           mdio_oe,
  input  logic           mdio_i
);
  localparam logic [DIV_W-1:0] DEF_M1 = DIV_W'(DEF_DIV - 1);
  localparam int SR_W  = $clog2(RST_CYCLES + 1);
  localparam int CMD_W = 16;

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [DIV_W-1:0]  div_q;
  logic              sup_q;
  logic [SR_W-1:0]   sr_cnt;
  logic              sr_active;
  logic              srst_req;
  logic              wr_ok;
  logic              cmd_go;
  logic              eng_busy;
  logic              bit_end;
  logic              rise_now;
  logic              rd_fin;
  logic [DATA_W-1:0] rd_word;
  logic [RDW-1:0]    sctl_word;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[RDW-1:CMD_W];

  always_comb begin
    sr_active = (sr_cnt != '0);
    srst_req  = reg_we && (reg_addr == ADDR_SCTL) && reg_wdata[SCTL_RST_BIT] && !sr_active;
    wr_ok     = reg_we && !eng_busy && !sr_active;
    cmd_go    = wr_ok && (reg_addr == ADDR_CMD) &&
                (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
    sctl_word = '0;
    sctl_word[SCTL_DIV_LSB +: DIV_W] = div_q;
    sctl_word[SCTL_SUP_BIT] = sup_q;
    sctl_word[SCTL_RST_BIT] = sr_active;
  end

  mdio_div_phase #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (eng_busy && !srst_req),
    .div_m1   (div_q),
    .mdc      (mdc),
    .bit_end  (bit_end),
    .rise_now (rise_now)
  );

  mdio_frame_eng #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (cmd_go),
    .abort    (srst_req),
    .op_rd    (reg_wdata[CMD_RD_BIT]),
    .skip_pre (sup_q),
    .phy      (reg_wdata[ADR_W +: ADR_W]),
    .regn     (reg_wdata[0 +: ADR_W]),
    .wdata    (data_q),
    .bit_end  (bit_end),
    .rise_now (rise_now),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_fin   (rd_fin),
    .rd_word  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
      div_q  <= DEF_M1;
      sup_q  <= 1'b0;
      sr_cnt <= '0;
    end else if (srst_req) begin
      cmd_q  <= '0;
      data_q <= '0;
      div_q  <= DEF_M1;
      sup_q  <= 1'b0;
      sr_cnt <= SR_W'(RST_CYCLES);
    end else if (sr_active) begin
      sr_cnt <= sr_cnt - SR_W'(1);
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          ADDR_CMD:  cmd_q  <= {reg_wdata[CMD_RD_BIT:CMD_WR_BIT], 4'b0000,
                                reg_wdata[2*ADR_W-1:0]};
          ADDR_DATA: data_q <= reg_wdata[DATA_W-1:0];
          ADDR_SCTL: begin
            div_q <= reg_wdata[SCTL_DIV_LSB +: DIV_W];
            sup_q <= reg_wdata[SCTL_SUP_BIT];
          end
          default: ;
        endcase
      end
      if (rd_fin) data_q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_CMD:  reg_rdata <= RDW'(cmd_q);
        ADDR_DATA: reg_rdata <= RDW'(data_q);
        ADDR_STAT: reg_rdata <= RDW'(eng_busy);
        default:   reg_rdata <= sctl_word;
      endcase
    end
  end

  AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> (!mdc && !mdio_oe)); // R7
  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(reg_we && (reg_addr == ADDR_CMD) &&
                              (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]))); // R2
  AST_REGS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && $past(eng_busy)) |-> ($stable(cmd_q) && $stable(data_q) && $stable(div_q))); // R8
  AST_NO_XFER_IN_SRST: assert property (@(posedge clk) disable iff (rst)
    sr_active |-> !eng_busy); // R9
endmodule

// File: tb/test_mdio_cmd_ctrl.sv
module test_mdio_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mdio_cmd_ctrl i_mdio_cmd_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // bit capture at each rising MDC edge
  int   rise_total = 0;
  logic cap_v  [0:2047];
  logic cap_oe [0:2047];
  always @(posedge mdc) begin
    if (rise_total < 2048) begin
      cap_v[rise_total]  = mdio_o;
      cap_oe[rise_total] = mdio_oe;
    end
    rise_total++;
  end

  // PHY model: drives read data after each falling MDC edge
  int          phy_base = 0;
  int          phy_hdr  = 0;
  logic [15:0] phy_resp = 16'h0;
  always @(negedge mdc) begin
    int j;
    j = rise_total - phy_base - phy_hdr - 16;
    if (j >= 0 && j < 16) mdio_i = phy_resp[15-j];
    else mdio_i = 1'b1;
  end

  // {op2, sup, div field, phy, reg, write data, phy response}
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {2'b10, 1'b0, 6'd3, 5'd1,  5'd2,  16'h0000, 16'hA5C3},
    {2'b01, 1'b0, 6'd3, 5'd31, 5'd0,  16'h1234, 16'h0000},
    {2'b10, 1'b1, 6'd3, 5'd0,  5'd31, 16'h0000, 16'h8001},
    {2'b01, 1'b1, 6'd0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000},
    {2'b11, 1'b1, 6'd4, 5'd7,  5'd9,  16'h5555, 16'h3C0F},
    {2'b01, 1'b0, 6'd1, 5'h0A, 5'h15, 16'h8000, 16'h0000}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    reg_addr = 2'd2;
    @(negedge clk);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!reg_rdata[0]) break;
    end
  endtask

  task automatic cmp_frame(input logic [1:0] op2, input logic sup, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd, input int base,
                           input string tag);
    logic        rdop;
    logic [31:0] body, obody;
    logic [63:0] ev, eo;
    int          bits, mism;
    rdop  = op2[1];
    body  = {2'b01, (rdop ? 2'b10 : 2'b01), phy, rg, (rdop ? 2'b00 : 2'b10),
             (rdop ? 16'h0000 : wd)};
    obody = rdop ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
    ev    = sup ? {body, 32'h0}  : {32'hFFFF_FFFF, body};
    eo    = sup ? {obody, 32'h0} : {32'hFFFF_FFFF, obody};
    bits  = sup ? 32 : 64;
    chk({tag, " R3 R4 bit periods"}, rise_total - base, bits);
    mism = 0;
    for (int i = 0; i < bits; i++) begin
      if (cap_oe[base+i] !== eo[63-i]) mism++;
      else if (eo[63-i] && (cap_v[base+i] !== ev[63-i])) mism++;
    end
    chk({tag, " R3 R5 frame bits"}, mism, 0);
  endtask

  task automatic xfer(input logic [1:0] op2, input logic sup, input logic [5:0] div,
                      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                      input logic [15:0] resp, input string tag);
    int          n, bits, busy_cnt, hi_cnt, base;
    logic [31:0] v;
    n    = (div == 0) ? 2 : int'(div) + 1;
    bits = sup ? 32 : 64;
    wr(2'd3, (32'(div) << 9) | (32'(sup) << 8));
    wr(2'd1, {16'h0, wd});
    phy_resp = resp;
    phy_hdr  = sup ? 0 : 32;
    base     = rise_total;
    phy_base = base;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = {16'h0, op2, 4'h0, phy, rg};
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
    busy_cnt = 0; hi_cnt = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (mdc) hi_cnt++;
      if (reg_rdata[0]) busy_cnt++;
      else break;
    end
    chk({tag, " R6 R7 busy clocks"}, busy_cnt, bits * n);
    chk({tag, " R6 mdc high clocks"}, hi_cnt, bits * (n - n / 2));
    cmp_frame(op2, sup, phy, rg, wd, base, tag);
    rd(2'd1, v);
    chk({tag, " R5 R3 data word"}, v, op2[1] ? resp : wd);
    chk({tag, " R7 idle line"}, {mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          base, cnt;
    rst = 1'b1; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset values at each address
    chk("R1 mdc oe", {mdc, mdio_oe}, 0);
    rd(2'd0, v); chk("R1 R10 command word", v, 0);
    rd(2'd1, v); chk("R1 R10 data word", v, 0);
    rd(2'd2, v); chk("R1 R10 status word", v, 0);
    rd(2'd3, v); chk("R1 R10 self-control word", v, 32'h4E00);

    // table of frames
    for (int t = 0; t < NV; t++) begin
      xfer(VEC[t][50:49], VEC[t][48], VEC[t][47:42], VEC[t][41:37], VEC[t][36:32],
           VEC[t][31:16], VEC[t][15:0], $sformatf("vec%0d", t));
    end

    // R6: default divisor 40, preamble suppressed
    xfer(2'b01, 1'b1, 6'd39, 5'd5, 5'd6, 16'hC3A5, 16'h0, "div40");

    // R2: command without operation bits starts nothing; R10 readback
    base = rise_total;
    wr(2'd0, 32'h0000_0123);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R2 no-op status", v, 0);
    chk("R2 no-op rises", rise_total - base, 0);
    rd(2'd0, v); chk("R10 R2 command readback", v, 32'h0123);

    // R8: writes while busy are ignored
    wr(2'd3, 32'd3 << 9);
    wr(2'd1, 32'h0000_BEEF);
    base = rise_total;
    wr(2'd0, 32'h4000 | (32'd3 << 5) | 32'd4);
    repeat (30) @(negedge clk);
    wr(2'd1, 32'h0000_1111);
    wr(2'd0, 32'h8000 | (32'd9 << 5) | 32'd1);
    wr(2'd3, 32'h0000_0100);
    wait_idle();
    cmp_frame(2'b01, 1'b0, 5'd3, 5'd4, 16'hBEEF, base, "R8 busy ignore");
    rd(2'd1, v); chk("R8 data kept", v, 32'hBEEF);
    rd(2'd3, v); chk("R8 self-control kept", v, 32'd3 << 9);
    rd(2'd0, v); chk("R8 command kept", v, 32'h4000 | (32'd3 << 5) | 32'd4);

    // R9: soft reset mid-transfer
    wr(2'd1, 32'h0000_7777);
    wr(2'd3, 32'h0000_0100 | (32'd3 << 9));
    wr(2'd0, 32'h4000 | 32'd2);
    repeat (40) @(negedge clk);
    wr(2'd3, 32'h0000_0001);
    chk("R9 line quiet after abort", {mdc, mdio_oe}, 0);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (reg_rdata[0]) cnt++;
      else break;
    end
    chk("R9 reset bit duration", cnt, 8);
    base = rise_total;
    rd(2'd2, v); chk("R9 busy cleared", v, 0);
    rd(2'd3, v); chk("R9 self-control defaults", v, 32'h4E00);
    rd(2'd1, v); chk("R9 data cleared", v, 0);
    repeat (20) @(negedge clk);
    chk("R9 no MDC after abort", rise_total - base, 0);

    // R9: writes during soft reset are ignored
    wr(2'd3, 32'h0000_0001);
    wr(2'd0, 32'h8000 | 32'd7);
    wr(2'd1, 32'h0000_0055);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R9 command ignored in reset", v, 0);
    rd(2'd1, v); chk("R9 data ignored in reset", v, 0);
    rd(2'd0, v); chk("R9 command word cleared", v, 0);
    chk("R9 no rises in reset", rise_total - base, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule